// File: doc/BRIEF.md
# Banked and Indirect Data Address Generator

This block produces the 12-bit data-space address for a small 8-bit controller core. The data space is split into 16 banks of 256 bytes. An instruction can name a location in one of four ways. It can give an 8-bit file field that goes through a fixed access window. It can give the same field combined with a 4-bit bank register. A two-word move can carry a full 12-bit absolute address. An instruction can also point through one of several pointer registers, and a pointer can advance by one after it is used.

The address is combinational from the current fields and register state. Writes to the bank register and to the pointers take effect at the next clock edge. A pointer can be loaded whole from a literal, or it can be written one byte at a time: bits 7:0 as the low byte and bits 11:8 as the high part. When software writes a pointer in the same cycle as an auto-increment of that pointer, the write wins.

Top module: `data_addr_gen`

## Requirements
- R1: After reset the bank register and every pointer hold 0.
- R2: With mode 2'b00 (direct) and access bit 0, a file field below 0x60 gives address 0x000 plus the field.
- R3: With mode 2'b00 and access bit 0, a file field of 0x60 or above gives address 0xF00 plus the field, which reaches the special registers.
- R4: With mode 2'b00 and access bit 1, the address is the bank register in bits 11:8 and the file field in bits 7:0. A bank register write changes the address from the next cycle on.
- R5: With mode 2'b01 (absolute), the address equals the 12-bit absolute input.
- R6: With mode 2'b10 (indirect), the address is the pointer chosen by the select input, and no pointer changes.
- R7: With mode 2'b11 (indirect, post-increment), the address is the chosen pointer's current value. That pointer then increases by one, wrapping from 0xFFF to 0x000.
- R8: A load strobe writes the 12-bit literal into the pointer named by the write select, taking effect at the next edge.
- R9: The low-byte write strobe replaces pointer bits 7:0 with byte data bits 7:0. The high write strobe replaces pointer bits 11:8 with byte data bits 3:0. All other pointer bits keep their values.
- R10: A load or byte write to a pointer in the same cycle as its post-increment overrides the increment. A load overrides byte writes.
- R11: A post-increment changes only the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Addressing mode: 00 direct, 01 absolute, 10 indirect, 11 indirect with post-increment |
| access_i | input | 1 | 0 selects the access window, 1 selects the bank register |
| file_i | input | 8 | File field of a direct instruction |
| abs_i | input | 12 | Absolute address from a two-word move |
| ptr_sel_i | input | 2 | Pointer used for indirect access |
| bank_we_i | input | 1 | Bank register write strobe |
| bank_wdata_i | input | 4 | New bank value |
| load_we_i | input | 1 | Whole-pointer load strobe |
| load_data_i | input | 12 | Literal for a whole-pointer load |
| lo_we_i | input | 1 | Pointer low-byte write strobe |
| hi_we_i | input | 1 | Pointer high-part write strobe |
| wsel_i | input | 2 | Pointer targeted by a load or byte write |
| byte_data_i | input | 8 | Data for byte writes |
| addr_o | output | 12 | Effective data address |
| ptr_o | output | 36 | All pointers, pointer k at bits 12k+11:12k |

## Verification
On every cycle, the assertions check how each pointer's next value follows from its strobes: increment, load, byte write, or hold. They also check that indirect modes route the selected pointer to the address, and that access-window addresses fall in the bottom or top page. The exact page boundary at 0x5F/0x60 is shown only by the bench's scenarios. So are the one-cycle delay before a bank write takes effect, the wrap from 0xFFF, and the combined cases where a byte write and a load collide with a post-increment.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_ABS     = 2'b01,
    MODE_IND     = 2'b10,
    MODE_IND_INC = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/dag_direct_map.sv
module dag_direct_map #(
  parameter int AW    = 12,
  parameter int FW    = 8,
  parameter int SPLIT = 'h60
) (
  input  logic              access_i,
  input  logic [FW-1:0]     file_i,
  input  logic [AW-FW-1:0]  bank_i,
  output logic [AW-1:0]     addr_o
);
  localparam int BW = AW - FW;

  always_comb begin
    if (access_i)
      addr_o = {bank_i, file_i};
    else if (int'(file_i) < SPLIT)
      addr_o = {{BW{1'b0}}, file_i};
    else
      addr_o = {{BW{1'b1}}, file_i};
  end
endmodule

// File: rtl/dag_ptr_reg.sv
module dag_ptr_reg #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_data_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [7:0]    byte_data_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam int HW = AW - 8;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_data_i;
    end else if (lo_we_i || hi_we_i) begin
      // software write beats increment
      if (lo_we_i) ptr_q[7:0]    <= byte_data_i;
      if (hi_we_i) ptr_q[AW-1:8] <= byte_data_i[HW-1:0];
    end else if (inc_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  // R7
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !lo_we_i && !hi_we_i |=> ptr_q == $past(ptr_q) + 1'b1);

  // R8
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_q == $past(load_data_i));

  // R10
  lo_over_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && lo_we_i && !load_i |=> ptr_q[7:0] == $past(byte_data_i));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !load_i && !lo_we_i && !hi_we_i |=> $stable(ptr_q));
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
#(
  parameter int AW      = 12,
  parameter int FW      = 8,
  parameter int NUM_PTR = 3,
  parameter int SPLIT   = 'h60
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic                  access_i,
  input  logic [7:0]            file_i,
  input  logic [11:0]           abs_i,
  input  logic [1:0]            ptr_sel_i,
  input  logic                  bank_we_i,
  input  logic [3:0]            bank_wdata_i,
  input  logic                  load_we_i,
  input  logic [11:0]           load_data_i,
  input  logic                  lo_we_i,
  input  logic                  hi_we_i,
  input  logic [1:0]            wsel_i,
  input  logic [7:0]            byte_data_i,
  output logic [11:0]           addr_o,
  output logic [35:0]           ptr_o
);
  localparam int BW  = AW - FW;
  localparam int PSW = $clog2(NUM_PTR);

  addr_mode_e    mode;
  logic [BW-1:0] bank_q;
  logic [AW-1:0] direct_addr;
  logic [AW-1:0] ptr_q [NUM_PTR];
  logic [AW-1:0] ptr_cur;

  assign mode = addr_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_q <= '0;
    else if (bank_we_i) bank_q <= bank_wdata_i;
  end

  dag_direct_map #(.AW(AW), .FW(FW), .SPLIT(SPLIT)) u_direct (
    .access_i (access_i),
    .file_i   (file_i),
    .bank_i   (bank_q),
    .addr_o   (direct_addr)
  );

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    logic hit_w, hit_r;
    assign hit_w = (wsel_i == PSW'(k));
    assign hit_r = (ptr_sel_i == PSW'(k));

    dag_ptr_reg #(.AW(AW)) u_ptr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_we_i && hit_w),
      .load_data_i (load_data_i),
      .lo_we_i     (lo_we_i && hit_w),
      .hi_we_i     (hi_we_i && hit_w),
      .byte_data_i (byte_data_i),
      .inc_i       ((mode == MODE_IND_INC) && hit_r),
      .ptr_o       (ptr_q[k])
    );
    assign ptr_o[k*AW +: AW] = ptr_q[k];
  end

  always_comb begin
    ptr_cur = '0;
    for (int k = 0; k < NUM_PTR; k++)
      if (ptr_sel_i == PSW'(k)) ptr_cur = ptr_q[k];
  end

  always_comb begin
    unique case (mode)
      MODE_DIRECT:  addr_o = direct_addr;
      MODE_ABS:     addr_o = abs_i;
      default:      addr_o = ptr_cur;
    endcase
  end

  // R6
  ind_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] && int'(ptr_sel_i) < NUM_PTR |-> addr_o == ptr_o[int'(ptr_sel_i)*AW +: AW]);

  // R2
  low_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_DIRECT && !access_i && int'(file_i) < SPLIT |-> addr_o[AW-1:FW] == '0);

  // R3
  top_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_DIRECT && !access_i && int'(file_i) >= SPLIT |-> &addr_o[AW-1:FW]);

  // R4
  bank_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_q == $past(bank_wdata_i));
endmodule

// File: tb/data_addr_gen_test.sv
module data_addr_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode = 0;
  logic        access = 0;
  logic [7:0]  file = 0;
  logic [11:0] abs_a = 0;
  logic [1:0]  ptr_sel = 0;
  logic        bank_we = 0;
  logic [3:0]  bank_wdata = 0;
  logic        load_we = 0;
  logic [11:0] load_data = 0;
  logic        lo_we = 0, hi_we = 0;
  logic [1:0]  wsel = 0;
  logic [7:0]  byte_data = 0;
  logic [11:0] addr;
  logic [35:0] ptrs;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  data_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .access_i(access), .file_i(file),
    .abs_i(abs_a), .ptr_sel_i(ptr_sel), .bank_we_i(bank_we), .bank_wdata_i(bank_wdata),
    .load_we_i(load_we), .load_data_i(load_data), .lo_we_i(lo_we), .hi_we_i(hi_we),
    .wsel_i(wsel), .byte_data_i(byte_data), .addr_o(addr), .ptr_o(ptrs)
  );

  // {mode, access, file, abs, expected}; bank register holds 0xA
  localparam logic [34:0] VEC [8] = '{
    {2'b00, 1'b0, 8'h00, 12'h000, 12'h000},
    {2'b00, 1'b0, 8'h5F, 12'h000, 12'h05F},
    {2'b00, 1'b0, 8'h60, 12'h000, 12'hF60},
    {2'b00, 1'b0, 8'hFF, 12'h000, 12'hFFF},
    {2'b00, 1'b1, 8'h34, 12'h000, 12'hA34},
    {2'b00, 1'b1, 8'h60, 12'h000, 12'hA60},
    {2'b01, 1'b0, 8'h12, 12'h7C3, 12'h7C3},
    {2'b01, 1'b1, 8'h00, 12'hFFF, 12'hFFF}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] p(input int k);
    return ptrs[k*12 +: 12];
  endfunction

  task automatic idle();
    mode = 2'b10; bank_we = 0; load_we = 0; lo_we = 0; hi_we = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic load(input logic [1:0] k, input logic [11:0] v);
    idle(); load_we = 1; wsel = k; load_data = v; step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    // R1
    chk("R1 ptr0", p(0), 12'h000);
    chk("R1 ptr1", p(1), 12'h000);
    chk("R1 ptr2", p(2), 12'h000);
    mode = 2'b00; access = 1; file = 8'h12; #1;
    chk("R1 bank", addr, 12'h012);

    bank_we = 1; bank_wdata = 4'hA; step(); bank_we = 0;
    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][34:33]; access = VEC[i][32]; file = VEC[i][31:24]; abs_a = VEC[i][23:12];
      #1;
      // R2 R3 R4 R5
      chk($sformatf("R2/R3/R4/R5 vec %0d", i), addr, VEC[i][11:0]);
    end

    // R4 bank write delay
    mode = 2'b00; access = 1; file = 8'h10; bank_we = 1; bank_wdata = 4'h3; #1;
    chk("R4 before edge", addr, 12'hA10);
    step(); bank_we = 0; #1;
    chk("R4 after edge", addr, 12'h310);

    load(2'd0, 12'h100); load(2'd1, 12'hFFF); load(2'd2, 12'h2AB);
    // R8
    chk("R8 ptr0", p(0), 12'h100);
    chk("R8 ptr1", p(1), 12'hFFF);
    chk("R8 ptr2", p(2), 12'h2AB);

    mode = 2'b10; ptr_sel = 2; #1;
    chk("R6 addr", addr, 12'h2AB);
    step();
    chk("R6 hold", p(2), 12'h2AB);

    mode = 2'b11; ptr_sel = 0; #1;
    chk("R7 addr", addr, 12'h100);
    step(); idle();
    chk("R7 inc", p(0), 12'h101);
    chk("R11 ptr1", p(1), 12'hFFF);
    chk("R11 ptr2", p(2), 12'h2AB);

    mode = 2'b11; ptr_sel = 1; #1;
    chk("R7 addr wrap", addr, 12'hFFF);
    step(); idle();
    chk("R7 wrap", p(1), 12'h000);

    lo_we = 1; wsel = 2; byte_data = 8'h55; step(); idle();
    chk("R9 lo", p(2), 12'h255);
    hi_we = 1; wsel = 2; byte_data = 8'hFC; step(); idle();
    chk("R9 hi", p(2), 12'hC55);

    mode = 2'b11; ptr_sel = 0; lo_we = 1; wsel = 0; byte_data = 8'h80; step(); idle();
    chk("R10 lo over inc", p(0), 12'h180);
    mode = 2'b11; ptr_sel = 0; load_we = 1; load_data = 12'h3F0; lo_we = 1; wsel = 0;
    byte_data = 8'h11; step(); idle();
    chk("R10 load over all", p(0), 12'h3F0);
    mode = 2'b11; ptr_sel = 0; hi_we = 1; wsel = 2; byte_data = 8'h01; step(); idle();
    chk("R10 other ptr inc", p(0), 12'h3F1);
    chk("R9 other ptr hi", p(2), 12'h155);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule